// File: doc/BRIEF.md
# Modem host status and interrupt controller

This block gives a host processor a single status byte and one active-low interrupt line for a byte-oriented MSK data modem. It gathers single-cycle event strobes from the receive and transmit datapaths: a byte entering the receive buffer, detection of a frame word, a checksum match, the live carrier indication, and the move of the transmit buffer into the shift register. It turns them into latched status flags. A bit-period tick drives an internal interval timer that posts its own flag.

Flags that carry a request to the host clear only through a two-step handshake. The host reads the status byte and then performs the matching buffer access. A buffer access that no status read has preceded leaves the flag standing. Dropping the receive or transmit enable clears that side's flags at once. The interrupt line is low whenever any interrupt-capable flag is latched.

Top module: `modem_status_irq`

## Requirements
- R1: After reset `status` is 8'h00 and `irq_n` is 1.
- R2: Status bit 0 (receive ready) sets, and `irq_n` goes low, on the clock edge of a `byte_loaded` strobe, but only if a `frame_found` strobe arrived on an earlier edge while `rx_en` was high. A byte loaded before any frame word leaves bit 0 at 0.
- R3: Bits 0 and 1 clear on a `rxbuf_rd` edge only if a `stat_rd` edge came earlier while the flag was set. A `rxbuf_rd` without that earlier status read leaves them set.
- R4: When `rx_en` is low, bits 0 and 1 are 0 on the next edge and the frame-seen state is forgotten. A later byte needs a new frame word.
- R5: Status bit 1 (checksum true) sets on a `csum_ok` strobe while `rx_en` is high. It never drives `irq_n` low.
- R6: Status bit 2 follows `carrier AND rx_en` one edge later, unlatched. It never drives `irq_n` low.
- R7: Status bit 3 (transmit ready) sets with `irq_n` low on a `tx_moved` strobe while `tx_en` is high.
- R8: A rising edge of `tx_en` sets bit 3 without driving `irq_n` low.
- R9: Bit 3 and its interrupt clear on a `txbuf_wr` edge that an earlier `stat_rd` preceded, and they clear when `tx_en` is low.
- R10: A `timer_wr` edge loads the 4-bit field N. With N=0 the timer never fires. With N from 1 to 15, status bit 4 sets with `irq_n` low on every 8·N-th `bit_tick` edge after the write.
- R11: Status bit 4 clears on a `stat_rd` edge or a `timer_wr` edge. A `timer_wr` restarts the tick count from zero.
- R12: When a set event and a clearing access fall on the same edge, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| byte_loaded | input | 1 | Byte written into receive buffer (strobe) |
| frame_found | input | 1 | Frame word detected (strobe) |
| csum_ok | input | 1 | Checksum comparison matched (strobe) |
| carrier | input | 1 | Live carrier detect |
| tx_moved | input | 1 | Transmit buffer moved to shift register (strobe) |
| bit_tick | input | 1 | One pulse per bit period |
| timer_wr | input | 1 | Timer field write strobe |
| timer_n | input | 4 | Timer field value N |
| stat_rd | input | 1 | Host read of status byte (strobe) |
| rxbuf_rd | input | 1 | Host read of receive buffer (strobe) |
| txbuf_wr | input | 1 | Host write of transmit buffer (strobe) |
| status | output | 8 | {3'b0, timer, tx ready, carrier, checksum, rx ready} |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default 4-bit timer field and eight bits per timer unit. At that size all fifteen nonzero timer settings can be swept in full. For each setting the bench checks that bit 4 is still clear one tick before 8·N and set exactly on it. The N=0 setting, the restart on rewrite, and every ordering of status read against buffer access on both sides, including same-edge set and clear, are driven directly.

// File: rtl/mhs_pkg.sv
package mhs_pkg;
  localparam int STATUS_W   = 8;
  localparam int BIT_RXRDY  = 0;
  localparam int BIT_CSUM   = 1;
  localparam int BIT_CARR   = 2;
  localparam int BIT_TXRDY  = 3;
  localparam int BIT_TIMER  = 4;
endpackage

// File: rtl/mhs_flag.sv
module mhs_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic hard_clr,
  input  logic stat_rd,
  input  logic access,
  output logic flag
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (set_ev) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else if (hard_clr || (armed && access)) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (stat_rd && flag) begin
      armed <= 1'b1;
    end
  end

  // R3
  unarmed_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !armed && !hard_clr) |=> flag);

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> flag);
endmodule

// File: rtl/mhs_timer.sv
module mhs_timer #(
  parameter int NW  = 4,
  parameter int BPU = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr,
  input  logic [NW-1:0] n_in,
  output logic          fire
);
  localparam int MAXP = BPU * ((1 << NW) - 1);
  localparam int CW   = $clog2(MAXP + 1);

  logic [NW-1:0] n_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] period;

  assign period = CW'(BPU) * CW'(n_q);
  assign fire   = !wr && tick && (n_q != '0) && (cnt == period - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      n_q <= '0;
      cnt <= '0;
    end else if (wr) begin
      n_q <= n_in;
      cnt <= '0;
    end else if (n_q == '0) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= fire ? '0 : cnt + 1'b1;
    end
  end

  // R10
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (n_q != '0) |-> (cnt < period));

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (n_q == '0 && !wr) |=> (cnt == '0));
endmodule

// File: rtl/modem_status_irq.sv
module modem_status_irq #(
  parameter int NW  = 4,
  parameter int BPU = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          tx_en,
  input  logic          byte_loaded,
  input  logic          frame_found,
  input  logic          csum_ok,
  input  logic          carrier,
  input  logic          tx_moved,
  input  logic          bit_tick,
  input  logic          timer_wr,
  input  logic [NW-1:0] timer_n,
  input  logic          stat_rd,
  input  logic          rxbuf_rd,
  input  logic          txbuf_wr,
  output logic [mhs_pkg::STATUS_W-1:0] status,
  output logic          irq_n
);
  import mhs_pkg::*;

  logic framed, car_q, tx_en_q, tmr_q;
  logic rxr, csm, txr, txi, fire;
  logic tx_rise;

  assign tx_rise = tx_en && !tx_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      framed  <= 1'b0;
      car_q   <= 1'b0;
      tx_en_q <= 1'b0;
      tmr_q   <= 1'b0;
    end else begin
      framed  <= rx_en && (framed || frame_found);
      car_q   <= carrier && rx_en;
      tx_en_q <= tx_en;
      if (fire)                     tmr_q <= 1'b1;
      else if (stat_rd || timer_wr) tmr_q <= 1'b0;
    end
  end

  mhs_flag u_rxr (.clk(clk), .rst(rst), .set_ev(rx_en && framed && byte_loaded),
    .hard_clr(!rx_en), .stat_rd(stat_rd), .access(rxbuf_rd), .flag(rxr));
  mhs_flag u_csm (.clk(clk), .rst(rst), .set_ev(rx_en && csum_ok),
    .hard_clr(!rx_en), .stat_rd(stat_rd), .access(rxbuf_rd), .flag(csm));
  mhs_flag u_txr (.clk(clk), .rst(rst), .set_ev(tx_en && (tx_moved || tx_rise)),
    .hard_clr(!tx_en), .stat_rd(stat_rd), .access(txbuf_wr), .flag(txr));
  mhs_flag u_txi (.clk(clk), .rst(rst), .set_ev(tx_en && tx_moved),
    .hard_clr(!tx_en), .stat_rd(stat_rd), .access(txbuf_wr), .flag(txi));

  mhs_timer #(.NW(NW), .BPU(BPU)) u_tmr (.clk(clk), .rst(rst), .tick(bit_tick),
    .wr(timer_wr), .n_in(timer_n), .fire(fire));

  always_comb begin
    status            = '0;
    status[BIT_RXRDY] = rxr;
    status[BIT_CSUM]  = csm;
    status[BIT_CARR]  = car_q;
    status[BIT_TXRDY] = txr;
    status[BIT_TIMER] = tmr_q;
  end

  assign irq_n = !(rxr || txi || tmr_q);

  // R4
  rx_off_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> (status[BIT_RXRDY] == 1'b0 && status[BIT_CSUM] == 1'b0));

  // R6
  carrier_off_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !status[BIT_CARR]);

  // R9
  tx_off_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> !status[BIT_TXRDY]);

  // R11
  timer_wr_clr_chk: assert property (@(posedge clk) disable iff (rst)
    timer_wr |=> !status[BIT_TIMER]);
endmodule

// File: tb/modem_status_irq_tb_top.sv
module modem_status_irq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 0, tx_en = 0, byte_loaded = 0, frame_found = 0, csum_ok = 0;
  logic carrier = 0, tx_moved = 0, bit_tick = 0, timer_wr = 0;
  logic [3:0] timer_n = 0;
  logic stat_rd = 0, rxbuf_rd = 0, txbuf_wr = 0;
  logic [7:0] status;
  logic irq_n;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  modem_status_irq dut_i (.clk(clk), .rst(rst), .rx_en(rx_en), .tx_en(tx_en),
    .byte_loaded(byte_loaded), .frame_found(frame_found), .csum_ok(csum_ok),
    .carrier(carrier), .tx_moved(tx_moved), .bit_tick(bit_tick),
    .timer_wr(timer_wr), .timer_n(timer_n), .stat_rd(stat_rd),
    .rxbuf_rd(rxbuf_rd), .txbuf_wr(txbuf_wr), .status(status), .irq_n(irq_n));

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_rd();  stat_rd = 1;  cyc(); stat_rd = 0;  endtask
  task automatic pulse_rx();  rxbuf_rd = 1; cyc(); rxbuf_rd = 0; endtask
  task automatic pulse_tx();  txbuf_wr = 1; cyc(); txbuf_wr = 0; endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 0;
    cyc();
    // R1 reset state, status and irq_n as one 9-bit word
    chk("R1", {status, irq_n}, {8'h00, 1'b1});

    // R2 byte before frame word is ignored
    rx_en = 1; cyc();
    byte_loaded = 1; cyc(); byte_loaded = 0;
    chk("R2 no frame", {status, irq_n}, {8'h00, 1'b1});
    frame_found = 1; cyc(); frame_found = 0;
    byte_loaded = 1; cyc(); byte_loaded = 0;
    chk("R2 framed", {status, irq_n}, {8'h01, 1'b0});

    // R5 checksum no interrupt contribution
    csum_ok = 1; cyc(); csum_ok = 0;
    chk("R5", {status, irq_n}, {8'h03, 1'b0});

    // R3 buffer read without status read keeps flags
    pulse_rx();
    chk("R3 unarmed", {status, irq_n}, {8'h03, 1'b0});
    pulse_rd(); pulse_rx();
    chk("R3 armed", {status, irq_n}, {8'h00, 1'b1});

    // R5 checksum alone: bit1 set, irq_n high
    csum_ok = 1; cyc(); csum_ok = 0;
    chk("R5 alone", {status, irq_n}, {8'h02, 1'b1});
    pulse_rd(); pulse_rx();

    // R12 set and clearing access on same edge
    byte_loaded = 1; cyc(); byte_loaded = 0;
    pulse_rd();
    byte_loaded = 1; rxbuf_rd = 1; cyc(); byte_loaded = 0; rxbuf_rd = 0;
    chk("R12 rx", {status, irq_n}, {8'h01, 1'b0});
    pulse_rx();
    chk("R12 rearm", {status, irq_n}, {8'h01, 1'b0});

    // R4 rx_en low clears and forgets frame
    csum_ok = 1; cyc(); csum_ok = 0;
    rx_en = 0; cyc();
    chk("R4 clear", {status, irq_n}, {8'h00, 1'b1});
    rx_en = 1; cyc();
    byte_loaded = 1; cyc(); byte_loaded = 0;
    chk("R4 reframe", {status, irq_n}, {8'h00, 1'b1});

    // R6 carrier live, gated, no interrupt
    carrier = 1; cyc();
    chk("R6 on", {status, irq_n}, {8'h04, 1'b1});
    rx_en = 0; cyc();
    chk("R6 gated", {status, irq_n}, {8'h00, 1'b1});
    rx_en = 1; carrier = 0; cyc();
    chk("R6 off", {status, irq_n}, {8'h00, 1'b1});

    // R8 tx enable rise sets bit3 without interrupt
    tx_en = 1; cyc();
    chk("R8", {status, irq_n}, {8'h08, 1'b1});
    pulse_rd(); pulse_tx();
    chk("R9 clear", {status, irq_n}, {8'h00, 1'b1});

    // R7 tx_moved sets bit3 with interrupt
    tx_moved = 1; cyc(); tx_moved = 0;
    chk("R7", {status, irq_n}, {8'h08, 1'b0});
    pulse_tx();
    chk("R9 unarmed", {status, irq_n}, {8'h08, 1'b0});
    pulse_rd(); pulse_tx();
    chk("R9 armed", {status, irq_n}, {8'h00, 1'b1});
    tx_moved = 1; cyc(); tx_moved = 0;
    tx_en = 0; cyc();
    chk("R9 disable", {status, irq_n}, {8'h00, 1'b1});

    // R10 N=0 never fires
    timer_n = 0; timer_wr = 1; cyc(); timer_wr = 0;
    bit_tick = 1; cyc(200); bit_tick = 0;
    chk("R10 N0", {status, irq_n}, {8'h00, 1'b1});

    // R10 sweep every nonzero N
    for (int n = 1; n < 16; n++) begin
      timer_n = 4'(n); timer_wr = 1; cyc(); timer_wr = 0;
      bit_tick = 1; cyc(8 * n - 1);
      chk($sformatf("R10 N%0d early", n), {status, irq_n}, {8'h00, 1'b1});
      cyc(); bit_tick = 0;
      chk($sformatf("R10 N%0d fire", n), {status, irq_n}, {8'h10, 1'b0});
      pulse_rd();
      chk($sformatf("R11 N%0d rdclr", n), {status, irq_n}, {8'h00, 1'b1});
    end

    // R10 periodic: second period with N=1
    timer_n = 1; timer_wr = 1; cyc(); timer_wr = 0;
    bit_tick = 1; cyc(8); bit_tick = 0; pulse_rd();
    bit_tick = 1; cyc(8); bit_tick = 0;
    chk("R10 repeat", {status, irq_n}, {8'h10, 1'b0});

    // R11 timer write clears flag
    timer_n = 2; timer_wr = 1; cyc(); timer_wr = 0;
    chk("R11 wrclr", {status, irq_n}, {8'h00, 1'b1});

    // R11 rewrite restarts count
    bit_tick = 1; cyc(10); bit_tick = 0;
    timer_wr = 1; cyc(); timer_wr = 0;
    bit_tick = 1; cyc(15);
    chk("R11 restart early", {status, irq_n}, {8'h00, 1'b1});
    cyc(); bit_tick = 0;
    chk("R11 restart fire", {status, irq_n}, {8'h10, 1'b0});
    pulse_rd();

    // R12 timer fire and status read on the same edge
    bit_tick = 1; cyc(15); stat_rd = 1; cyc(); stat_rd = 0; bit_tick = 0;
    chk("R12 timer", {status, irq_n}, {8'h10, 1'b0});

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule